// File: doc/BRIEF.md
# Multiprocessor Boot Table Locator

Several processors may share a single boot memory. Each of them then has to find where its own boot sections begin before any section is parsed. This block does that search. The locator table sits directly after the boot kernel area, at word 256 of the boot memory. That word corresponds to byte offset 0x600 when bytes are packed six to a word.

The table holds seven 48-bit entries. In each entry, bits 47:16 are a 32-bit start offset and bits 15:0 are a 16-bit processor ID. A start pulse latches the local processor ID. The block then reads the entries one at a time, in ascending address order, through a simple word-read port. It compares each returned ID with the latched ID. On the first match it presents the entry's offset, which the section parser uses as the point where reading begins for this processor. If all seven entries miss, it raises a not-found flag instead.

Top module: `btl_locator`

## Requirements
- R1: After reset, `busy`, `rd_req`, `ofs_valid` and `not_found` are 0 and `start_ofs` is 0.
- R2: Every read request is a one-cycle `rd_req` pulse. Entry k is requested at word address 256+k, with k ascending from 0. No new request is raised until `rd_valid` has answered the previous one.
- R3: A returned entry word is split so that bits 47:16 are the start offset and bits 15:0 are the ID. The word 0x8002062A0001 yields offset 0x8002062A for ID 0x0001.
- R4: The search stops at the first entry whose ID equals the latched ID. It then drives `ofs_valid`=1 and `start_ofs` with that entry's offset, and issues no further reads. When the same ID appears in several entries, the lowest-addressed one wins.
- R5: If none of the seven entries matches, the search ends after exactly seven reads with `not_found`=1, `ofs_valid`=0 and `start_ofs`=0.
- R6: A `start` seen while idle clears `ofs_valid`, `not_found` and `start_ofs` and raises `busy` in the next cycle. Once the search ends, the results stay unchanged until the next accepted `start`.
- R7: A `start` pulse while `busy` is 1 is ignored. The running search continues with its original ID and read sequence.
- R8: `rd_valid` arriving while no read is outstanding has no effect on the results or on the state.
- R9: The local ID is captured on the accepted `start`. Changes on `local_id` during a search do not affect its outcome.
- R10: `ofs_valid` and `not_found` are never both 1, and both are 0 while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (one-cycle pulse) |
| local_id | input | 16 | Processor ID of this processor |
| rd_req | output | 1 | Word read request to boot memory |
| rd_addr | output | 24 | Word address of the requested entry |
| rd_valid | input | 1 | Read data is valid this cycle |
| rd_data | input | 48 | Returned table entry |
| busy | output | 1 | Search in progress |
| ofs_valid | output | 1 | A matching entry was found |
| not_found | output | 1 | No entry matched |
| start_ofs | output | 32 | Start offset from the matching entry |

## Verification
The hardest situations to reach are those where the block must ignore something mid-search: a second start, a changing local ID, or read data that no request asked for. Each of these has to land while a read is actually in flight or while the block sits idle holding a result. The bench's memory model therefore stretches read latency per run. This keeps the search busy long enough to inject a stray start and an ID change between requests. Unsolicited read strobes carrying a matching word are injected only once the search has finished. The table also places a duplicated ID in two entries, so that first-match ordering is observable in both the offset and the read count.

// File: rtl/btl_pkg.sv
package btl_pkg;

    localparam int OFS_W       = 32;
    localparam int ID_W        = 16;
    localparam int WORD_W      = OFS_W + ID_W;
    localparam int ADDR_W      = 24;
    localparam int TBL_BASE    = 256;
    localparam int TBL_ENTRIES = 7;

    typedef struct packed {
        logic [OFS_W-1:0] ofs;
        logic [ID_W-1:0]  id;
    } entry_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } state_t;

    function automatic entry_t unpack_entry(input logic [WORD_W-1:0] w);
        entry_t e;
        e.ofs = w[WORD_W-1:ID_W];
        e.id  = w[ID_W-1:0];
        return e;
    endfunction

endpackage

// File: rtl/btl_match.sv
module btl_match
    import btl_pkg::*;
#(
    parameter int P_OFS_W = OFS_W,
    parameter int P_ID_W  = ID_W,
    localparam int L_WORD_W = P_OFS_W + P_ID_W
) (
    input  logic [L_WORD_W-1:0] word,
    input  logic [P_ID_W-1:0]   ref_id,
    output logic                hit,
    output logic [P_OFS_W-1:0]  ofs
);

    entry_t ent;

    always_comb begin
        ent = unpack_entry(word);
        hit = (ent.id == ref_id);
        ofs = ent.ofs;
    end

endmodule

// File: rtl/btl_seq.sv
module btl_seq
    import btl_pkg::*;
#(
    parameter int P_ID_W    = ID_W,
    parameter int P_ADDR_W  = ADDR_W,
    parameter int P_BASE    = TBL_BASE,
    parameter int P_ENTRIES = TBL_ENTRIES,
    localparam int L_IDX_W  = (P_ENTRIES > 1) ? $clog2(P_ENTRIES) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [P_ID_W-1:0]   local_id,
    input  logic                rd_valid,
    input  logic                hit,
    output logic                rd_req,
    output logic [P_ADDR_W-1:0] rd_addr,
    output logic                busy,
    output logic                accept,
    output logic                hit_stb,
    output logic                miss_stb,
    output logic [P_ID_W-1:0]   id_q
);

    localparam logic [L_IDX_W-1:0] L_LAST = L_IDX_W'(P_ENTRIES - 1);

    state_t             state;
    logic [L_IDX_W-1:0] idx;
    logic               last;

    always_comb begin
        busy     = (state != ST_IDLE);
        rd_req   = (state == ST_REQ);
        rd_addr  = P_ADDR_W'(P_BASE) + P_ADDR_W'(idx);
        accept   = start && (state == ST_IDLE);
        last     = (idx == L_LAST);
        hit_stb  = (state == ST_WAIT) && rd_valid && hit;
        miss_stb = (state == ST_WAIT) && rd_valid && !hit && last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
            id_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    id_q  <= local_id;
                    idx   <= '0;
                    state <= ST_REQ;
                end
                ST_REQ: state <= ST_WAIT;
                ST_WAIT: if (rd_valid) begin
                    if (hit || last) begin
                        state <= ST_IDLE;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= ST_REQ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: a request lasts one cycle
    p_req_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> !rd_req);

    // R2: requests stay inside the table window
    p_addr_window_r2: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_addr >= P_ADDR_W'(P_BASE)) &&
                   (rd_addr <  P_ADDR_W'(P_BASE + P_ENTRIES)));

    // R6: an idle start makes the block busy next cycle
    p_start_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R7, R9: the latched ID does not move during a search
    p_id_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(id_q));

endmodule

// File: rtl/btl_result.sv
module btl_result
    import btl_pkg::*;
#(
    parameter int P_OFS_W = OFS_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               hit_stb,
    input  logic               miss_stb,
    input  logic [P_OFS_W-1:0] ofs_in,
    output logic               ofs_valid,
    output logic               not_found,
    output logic [P_OFS_W-1:0] start_ofs
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ofs_valid <= 1'b0;
            not_found <= 1'b0;
            start_ofs <= '0;
        end else if (hit_stb) begin
            ofs_valid <= 1'b1;
            start_ofs <= ofs_in;
        end else if (miss_stb) begin
            not_found <= 1'b1;
        end
    end

    // R10: the two outcome flags exclude each other
    p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(ofs_valid && not_found));

    // R6: results hold while nothing new arrives
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !hit_stb && !miss_stb) |=>
            $stable(start_ofs) && $stable(ofs_valid) && $stable(not_found));

endmodule

// File: rtl/btl_locator.sv
module btl_locator
    import btl_pkg::*;
#(
    parameter int P_OFS_W   = OFS_W,
    parameter int P_ID_W    = ID_W,
    parameter int P_ADDR_W  = ADDR_W,
    parameter int P_BASE    = TBL_BASE,
    parameter int P_ENTRIES = TBL_ENTRIES,
    localparam int L_WORD_W = P_OFS_W + P_ID_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [P_ID_W-1:0]   local_id,
    output logic                rd_req,
    output logic [P_ADDR_W-1:0] rd_addr,
    input  logic                rd_valid,
    input  logic [L_WORD_W-1:0] rd_data,
    output logic                busy,
    output logic                ofs_valid,
    output logic                not_found,
    output logic [P_OFS_W-1:0]  start_ofs
);

    logic              hit, accept, hit_stb, miss_stb;
    logic [P_ID_W-1:0] id_q;
    logic [P_OFS_W-1:0] cand_ofs;

    btl_match #(.P_OFS_W(P_OFS_W), .P_ID_W(P_ID_W)) u_match (
        .word   (rd_data),
        .ref_id (id_q),
        .hit    (hit),
        .ofs    (cand_ofs)
    );

    btl_seq #(
        .P_ID_W(P_ID_W), .P_ADDR_W(P_ADDR_W),
        .P_BASE(P_BASE), .P_ENTRIES(P_ENTRIES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .local_id (local_id),
        .rd_valid (rd_valid),
        .hit      (hit),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .busy     (busy),
        .accept   (accept),
        .hit_stb  (hit_stb),
        .miss_stb (miss_stb),
        .id_q     (id_q)
    );

    btl_result #(.P_OFS_W(P_OFS_W)) u_result (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept),
        .hit_stb   (hit_stb),
        .miss_stb  (miss_stb),
        .ofs_in    (cand_ofs),
        .ofs_valid (ofs_valid),
        .not_found (not_found),
        .start_ofs (start_ofs)
    );

    // R10: no outcome is shown while searching
    p_quiet_busy_r10: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!ofs_valid && !not_found));

endmodule

// File: tb/tb_btl_locator.sv
module tb_btl_locator;

    localparam int CLK_PERIOD = 10;
    localparam int BASE = 256;
    localparam int NENT = 7;

    typedef struct {
        logic [15:0] id;
        logic        found;
        logic [31:0] ofs;
        int          reads;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] local_id = '0;
    logic        rd_req;
    logic [23:0] rd_addr;
    logic        rd_valid = 1'b0;
    logic [47:0] rd_data = '0;
    logic        busy, ofs_valid, not_found;
    logic [31:0] start_ofs;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [47:0] mem [NENT];
    exp_t        sb_q[$];

    int  lat = 0;
    int  lat_cnt = 0;
    bit  pend = 0;
    int  req_cnt = 0;
    int  spur_cnt = 0;
    logic [47:0] spur_data = '0;
    bit  busy_d = 0;

    btl_locator dut (
        .clk(clk), .rst(rst), .start(start), .local_id(local_id),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .busy(busy), .ofs_valid(ofs_valid),
        .not_found(not_found), .start_ofs(start_ofs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model: one outstanding read, programmable latency
    always @(negedge clk) begin
        cyc++;
        rd_valid = 1'b0;
        if (spur_cnt > 0) begin
            rd_valid = 1'b1;
            rd_data  = spur_data;
            spur_cnt--;
        end else if (pend) begin
            if (lat_cnt == 0) begin
                rd_valid = 1'b1;
                rd_data  = mem[req_cnt-1];
                pend     = 0;
            end else begin
                lat_cnt--;
            end
        end
        if (rd_req) begin
            chk(!pend, "R2 overlap", 64'(pend), 64'd0);
            chk(rd_addr == 24'(BASE + req_cnt), "R2 addr", 64'(rd_addr),
                64'(BASE + req_cnt));
            req_cnt++;
            pend    = 1;
            lat_cnt = lat;
        end
    end

    // monitor: compare on falling busy
    always @(negedge clk) begin
        if (!rst) begin
            if (ofs_valid && not_found)
                chk(0, "R10 both flags", 64'd1, 64'd0);
            if (busy_d && !busy) begin
                exp_t e;
                if (sb_q.size() == 0) begin
                    chk(0, "R4 unexpected result", 64'd1, 64'd0);
                end else begin
                    e = sb_q.pop_front();
                    chk(ofs_valid == e.found, {e.tag, " ofs_valid"},
                        64'(ofs_valid), 64'(e.found));
                    chk(not_found == !e.found, {e.tag, " not_found"},
                        64'(not_found), 64'(!e.found));
                    chk(start_ofs == e.ofs, {e.tag, " start_ofs"},
                        64'(start_ofs), 64'(e.ofs));
                    chk(req_cnt == e.reads, {e.tag, " reads"},
                        64'(req_cnt), 64'(e.reads));
                end
            end
        end
        busy_d = busy;
    end

    // driver: compute expectation, push, launch search
    task automatic run(input logic [15:0] id, input int l, input string tag,
                       input bit mid_start, input bit id_swap);
        exp_t e;
        e.id = id; e.found = 0; e.ofs = '0; e.reads = NENT; e.tag = tag;
        for (int k = 0; k < NENT; k++) begin
            if (!e.found && mem[k][15:0] == id) begin
                e.found = 1; e.ofs = mem[k][47:16]; e.reads = k + 1;
            end
        end
        sb_q.push_back(e);
        lat = l;
        req_cnt = 0;
        start = 1'b1; local_id = id;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R6 busy after start", 64'(busy), 64'd1);
        chk(!ofs_valid && !not_found && start_ofs == 0, "R6 clear on start",
            {31'd0, ofs_valid, not_found, start_ofs}, 64'd0);
        if (id_swap) local_id = 16'h0001;
        if (mid_start) begin
            @(negedge clk); @(negedge clk);
            start = 1'b1; local_id = 16'h0001;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        mem[0] = 48'h8002062A_0001;
        mem[1] = 48'h00001000_0002;
        mem[2] = 48'h00002000_0005;
        mem[3] = 48'h00003000_0003;
        mem[4] = 48'h00004000_0005;
        mem[5] = 48'hFFFFFFFF_FFFF;
        mem[6] = 48'h00006000_0007;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !rd_req && !ofs_valid && !not_found && start_ofs == 0,
            "R1 reset", {28'd0, busy, rd_req, ofs_valid, not_found, start_ofs}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !rd_req, "R1 idle after reset", {62'd0, busy, rd_req}, 64'd0);

        run(16'h0001, 0, "R3 decode entry0", 0, 0);
        run(16'h0007, 2, "R2 last entry", 0, 0);
        run(16'h0005, 1, "R4 first duplicate", 0, 0);
        run(16'hFFFF, 3, "R3 all-ones entry", 0, 0);
        run(16'h1234, 1, "R5 absent id", 0, 0);

        // R6 hold and R8 stray read strobes while idle
        run(16'h0003, 0, "R6 setup", 0, 0);
        spur_data = 48'hABCD0000_0003;
        spur_cnt  = 3;
        repeat (6) @(negedge clk);
        chk(ofs_valid && !not_found && start_ofs == 32'h00003000 && !busy,
            "R8 stray rd_valid ignored", {31'd0, ofs_valid, not_found, start_ofs},
            {32'h2, 32'h00003000});
        chk(!rd_req && req_cnt == 4, "R6 hold no new reads", 64'(req_cnt), 64'd4);

        spur_data = 48'h11110000_1234;
        spur_cnt  = 2;
        repeat (4) @(negedge clk);
        run(16'h1234, 0, "R8 miss after strays", 0, 0);

        run(16'h0007, 4, "R7 start while busy", 1, 0);
        run(16'h0006, 2, "R9 id change ignored", 0, 1);
        mem[3] = 48'h0BADF00D_0006;
        run(16'h0006, 0, "R9 new table entry", 0, 1);

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R4 scoreboard drained", 64'(sb_q.size()), 64'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc > 50000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<50000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule